// File: doc/BRIEF.md
# Frame Keep/Discard Arbiter

This block sits beside a receive MAC and settles, once per received frame, whether that frame is kept or thrown away. It weighs four things: a promiscuous-mode setting, the MAC's own address-match result, a set of filter-disable settings, and an active-low reject line driven by external address lookup logic. The verdict leaves the block as a single-cycle keep or drop pulse in the cycle after the frame-end strobe.

External logic may veto a frame only within a fixed window after the start-of-frame delimiter. The window is counted in byte-time ticks and defaults to 64 bytes (512 bit times). A low level on the reject line counts only if it stays low for a configured number of system clocks, so short glitches are filtered out. Promiscuous mode and a valid internal match both override any veto. When all the disable settings are active, the internal match flag is ignored. In that case the frame is kept unless it is vetoed.

Frames whose frame end arrives before the window has elapsed are runts. When runt acceptance is off they are dropped. When it is on they are judged like any other frame, so a veto that arrived before frame end still drops them. Every delimiter restarts the byte count and clears any recorded veto.

Top module: `frame_keep_decider`

## Requirements
- R1: After reset, and after a reset during a frame, `keep_o` and `drop_o` are low and a frame-end strobe without a new delimiter produces no pulse.
- R2: With `cfg_promisc`=1, a frame that is not a dropped runt is kept even if a veto occurred in the window.
- R3: When `addr_hit`=1 in the frame-end cycle and internal matching is not disabled, the frame is kept even if a veto occurred.
- R4: Internal matching is disabled when `cfg_promisc`=0, `cfg_no_bcast`=1, `cfg_no_phys`=1 and `cfg_lfilt_empty`=1. In that state `addr_hit` has no effect, so a vetoed frame is dropped and an unvetoed one is kept. If any one of the three filter settings is 0, `addr_hit` still keeps the frame.
- R5: A veto is `reject_n`=0 for at least `MIN_LOW_CLKS` consecutive clocks, all of them sampled while fewer than `WINDOW_BYTES` byte ticks have been counted since the delimiter. Such a veto drops the frame.
- R6: A low `reject_n` sampled after `WINDOW_BYTES` byte ticks have been counted has no effect.
- R7: A low run of `reject_n` shorter than `MIN_LOW_CLKS` clocks has no effect.
- R8: A full-length frame with no veto and no overriding setting is kept.
- R9: A frame that ends before `WINDOW_BYTES` byte ticks is a runt. With `cfg_runt_ok`=0 a runt is dropped, whatever the other inputs. With `cfg_runt_ok`=1 a runt is kept unless it was vetoed before frame end. A frame with exactly `WINDOW_BYTES` ticks is not a runt.
- R10: `frame_end` inside a frame gives exactly one of `keep_o`/`drop_o` high for one cycle, in the cycle after the strobe. `frame_end` outside a frame gives no pulse.
- R11: `sfd` clears the veto and the byte count, so a veto in one frame does not affect the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfd | input | 1 | One-cycle strobe: start-of-frame delimiter seen |
| byte_tick | input | 1 | One-cycle strobe per received byte time |
| frame_end | input | 1 | One-cycle strobe: frame reception complete |
| addr_hit | input | 1 | Internal address match result, sampled with `frame_end` |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_no_bcast | input | 1 | Broadcast receive disabled |
| cfg_no_phys | input | 1 | Physical address receive disabled |
| cfg_lfilt_empty | input | 1 | Logical address filter is all zero |
| cfg_runt_ok | input | 1 | Runt frames may be accepted |
| reject_n | input | 1 | Active-low external veto |
| keep_o | output | 1 | One-cycle pulse: frame kept |
| drop_o | output | 1 | One-cycle pulse: frame discarded |

## Verification
The bench places vetoes on both sides of the window edge. A veto starting at byte 62 must drop the frame, and one starting at byte 64 must not. A design with an off-by-one window would give the wrong verdict on one of these two frames. A three-clock low run checks the glitch filter, which a design that latches on the first low sample would fail. Other frames check the overrides: a hit flag under the full disable setting, the same flag with only two disables set, promiscuous mode against a veto, and runt frames with and without runt acceptance. Finally, the bench sends a vetoed frame followed by a clean one, a stray frame-end strobe, and a reset in mid-frame. These catch a veto that survives a delimiter or a reset, and a verdict issued outside a frame.

// File: rtl/fkd_pkg.sv
// Shared types and helpers for the frame keep/discard arbiter.
// Assumes: configuration bits are static during a frame.
package fkd_pkg;

    typedef struct packed {
        logic promisc;
        logic no_bcast;
        logic no_phys;
        logic lfilt_empty;
        logic runt_ok;
    } fkd_cfg_t;

    // True when every internal filter path is switched off.
    function automatic logic match_off(fkd_cfg_t c);
        return !c.promisc && c.no_bcast && c.no_phys && c.lfilt_empty;
    endfunction

endpackage

// File: rtl/fkd_window_timer.sv
// Tracks frame occupancy and counts byte ticks after the delimiter.
// The count saturates at WINDOW_BYTES. The veto window is open while
// the count is below it. Assumes sfd, byte_tick and frame_end are
// single-cycle strobes; sfd wins over frame_end in the same cycle.
module fkd_window_timer #(
    parameter int WINDOW_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sfd,
    input  logic byte_tick,
    input  logic frame_end,
    output logic win_open,
    output logic short_frame,
    output logic frame_close
);
    localparam int CW = $clog2(WINDOW_BYTES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW_BYTES);

    logic          in_frame;
    logic [CW-1:0] byte_cnt;

    // Frame occupancy and saturating byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            byte_cnt <= '0;
        end else if (sfd) begin
            in_frame <= 1'b1;
            byte_cnt <= '0;
        end else if (frame_end) begin
            in_frame <= 1'b0;
        end else if (byte_tick && in_frame && byte_cnt < LIMIT) begin
            byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // Window and frame-close indications.
    always_comb begin
        win_open    = in_frame && (byte_cnt < LIMIT);
        short_frame = byte_cnt < LIMIT;
        frame_close = frame_end && in_frame;
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= LIMIT);

    p_sfd_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sfd |=> (byte_cnt == '0) && win_open);

endmodule

// File: rtl/fkd_reject_filter.sv
// Glitch filter for the active-low veto line. A veto is recorded after
// MIN_LOW_CLKS consecutive low samples, all taken while the window is
// open. Assumes MIN_LOW_CLKS >= 1. The record clears on each delimiter.
module fkd_reject_filter #(
    parameter int MIN_LOW_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sfd,
    input  logic win_open,
    input  logic reject_n,
    output logic rej_hit
);
    localparam int LW = $clog2(MIN_LOW_CLKS + 1);
    localparam logic [LW-1:0] NEED = LW'(MIN_LOW_CLKS);

    logic [LW-1:0] low_cnt;

    // Count the low run inside the window; latch the veto when it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n || sfd) begin
            low_cnt <= '0;
            rej_hit <= 1'b0;
        end else if (win_open && !reject_n) begin
            if (low_cnt < NEED) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (low_cnt == NEED - 1'b1) begin
                rej_hit <= 1'b1;
            end
        end else begin
            low_cnt <= '0;
        end
    end

    p_rej_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rej_hit) |-> $past(win_open) && !$past(reject_n));

    p_sfd_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sfd |=> !rej_hit);

    p_rej_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_hit && !sfd) |=> rej_hit);

endmodule

// File: rtl/fkd_verdict.sv
// Registers the keep/drop verdict at frame close. Priority: runt drop,
// then promiscuous, then the effective internal match, then the veto.
// Assumes addr_hit is valid in the frame-close cycle.
module fkd_verdict
    import fkd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_close,
    input  logic     short_frame,
    input  fkd_cfg_t cfg,
    input  logic     addr_hit,
    input  logic     rej_hit,
    output logic     keep_o,
    output logic     drop_o
);
    logic runt_drop;
    logic hit_eff;
    logic keep_now;

    // Combine the configuration, the match flag and the veto into a keep decision.
    always_comb begin
        runt_drop = short_frame && !cfg.runt_ok;
        hit_eff   = addr_hit && !match_off(cfg);
        keep_now  = !runt_drop && (cfg.promisc || hit_eff || !rej_hit);
    end

    // Emit one pulse per frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_o <= 1'b0;
            drop_o <= 1'b0;
        end else begin
            keep_o <= frame_close && keep_now;
            drop_o <= frame_close && !keep_now;
        end
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(keep_o && drop_o));

    p_pulse_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_o || drop_o) |-> $past(frame_close));

    p_promisc_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_close && cfg.promisc && !(short_frame && !cfg.runt_ok)) |=> keep_o);

    p_runt_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_close && short_frame && !cfg.runt_ok) |=> drop_o);

endmodule

// File: rtl/frame_keep_decider.sv
// Top of the frame keep/discard arbiter. It chains the window timer, the
// veto glitch filter and the verdict register. Assumes all inputs are
// synchronous to clk.
module frame_keep_decider
    import fkd_pkg::*;
#(
    parameter int WINDOW_BYTES = 64,
    parameter int MIN_LOW_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sfd,
    input  logic byte_tick,
    input  logic frame_end,
    input  logic addr_hit,
    input  logic cfg_promisc,
    input  logic cfg_no_bcast,
    input  logic cfg_no_phys,
    input  logic cfg_lfilt_empty,
    input  logic cfg_runt_ok,
    input  logic reject_n,
    output logic keep_o,
    output logic drop_o
);
    fkd_cfg_t cfg;
    logic     win_open;
    logic     short_frame;
    logic     frame_close;
    logic     rej_hit;

    // Gather the configuration pins into one record.
    always_comb begin
        cfg = '{promisc:     cfg_promisc,
                no_bcast:    cfg_no_bcast,
                no_phys:     cfg_no_phys,
                lfilt_empty: cfg_lfilt_empty,
                runt_ok:     cfg_runt_ok};
    end

    fkd_window_timer #(.WINDOW_BYTES(WINDOW_BYTES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfd         (sfd),
        .byte_tick   (byte_tick),
        .frame_end   (frame_end),
        .win_open    (win_open),
        .short_frame (short_frame),
        .frame_close (frame_close)
    );

    fkd_reject_filter #(.MIN_LOW_CLKS(MIN_LOW_CLKS)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sfd      (sfd),
        .win_open (win_open),
        .reject_n (reject_n),
        .rej_hit  (rej_hit)
    );

    fkd_verdict u_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_close (frame_close),
        .short_frame (short_frame),
        .cfg         (cfg),
        .addr_hit    (addr_hit),
        .rej_hit     (rej_hit),
        .keep_o      (keep_o),
        .drop_o      (drop_o)
    );

endmodule

// File: tb/sim_frame_keep_decider.sv
// Self-checking bench: a vector table of frames, then directed corner cases.
module sim_frame_keep_decider;

    logic clk = 1'b0;
    logic rst_n, sfd, byte_tick, frame_end, addr_hit;
    logic cfg_promisc, cfg_no_bcast, cfg_no_phys, cfg_lfilt_empty, cfg_runt_ok;
    logic reject_n;
    logic keep_o, drop_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    frame_keep_decider #(.WINDOW_BYTES(64), .MIN_LOW_CLKS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .sfd(sfd), .byte_tick(byte_tick),
        .frame_end(frame_end), .addr_hit(addr_hit),
        .cfg_promisc(cfg_promisc), .cfg_no_bcast(cfg_no_bcast),
        .cfg_no_phys(cfg_no_phys), .cfg_lfilt_empty(cfg_lfilt_empty),
        .cfg_runt_ok(cfg_runt_ok), .reject_n(reject_n),
        .keep_o(keep_o), .drop_o(drop_o)
    );

    // Vector fields: [26] promisc [25] no_bcast [24] no_phys [23] lfilt_empty
    // [22] runt_ok [21] hit [20:13] veto start byte (255 = none)
    // [12:9] veto length in clocks [8:1] byte count [0] expect keep
    localparam int NV = 14;
    localparam logic [26:0] TBL [NV] = '{
        {5'b00000, 1'b0, 8'd255, 4'd0, 8'd70, 1'b1},  // R8 clean frame
        {5'b00000, 1'b0, 8'd10,  4'd6, 8'd70, 1'b0},  // R5 veto early
        {5'b10000, 1'b0, 8'd10,  4'd6, 8'd70, 1'b1},  // R2 promisc beats veto
        {5'b00000, 1'b1, 8'd10,  4'd6, 8'd70, 1'b1},  // R3 hit beats veto
        {5'b01110, 1'b1, 8'd10,  4'd6, 8'd70, 1'b0},  // R4 hit ignored when disabled
        {5'b01100, 1'b1, 8'd10,  4'd6, 8'd70, 1'b1},  // R4 filter still on
        {5'b01110, 1'b1, 8'd255, 4'd0, 8'd70, 1'b1},  // R4 disabled, no veto
        {5'b00000, 1'b0, 8'd64,  4'd6, 8'd70, 1'b1},  // R6 veto after window
        {5'b00000, 1'b0, 8'd62,  4'd4, 8'd70, 1'b0},  // R5 veto at window edge
        {5'b00000, 1'b0, 8'd10,  4'd3, 8'd70, 1'b1},  // R7 glitch too short
        {5'b00001, 1'b0, 8'd5,   4'd6, 8'd20, 1'b0},  // R9 runt vetoed
        {5'b00001, 1'b0, 8'd255, 4'd0, 8'd20, 1'b1},  // R9 runt accepted
        {5'b00000, 1'b0, 8'd255, 4'd0, 8'd20, 1'b0},  // R9 runt refused
        {5'b00000, 1'b0, 8'd255, 4'd0, 8'd64, 1'b1}   // R9 exactly window length
    };

    task automatic check(input string req, input logic k, input logic d,
                         input logic ek, input logic ed);
        n_checks++;
        if (k !== ek || d !== ed) begin
            n_fails++;
            $display("FAIL %s: keep/drop=%b%b expected %b%b", req, k, d, ek, ed);
        end
    endtask

    task automatic idle();
        sfd = 0; byte_tick = 0; frame_end = 0; addr_hit = 0; reject_n = 1;
    endtask

    // Drive one frame, then check the verdict pulse and the quiet cycle after it.
    task automatic run_frame(input logic [26:0] v, input string req);
        int rb, rl, nb;
        {cfg_promisc, cfg_no_bcast, cfg_no_phys, cfg_lfilt_empty, cfg_runt_ok} = v[26:22];
        rb = int'(v[20:13]);
        rl = int'(v[12:9]);
        nb = int'(v[8:1]);
        @(negedge clk); sfd = 1;
        @(negedge clk); sfd = 0;
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 4; k++) begin
                int c;
                c = b * 4 + k;
                byte_tick = (k == 0);
                reject_n  = !(rb != 255 && c >= rb * 4 && c < rb * 4 + rl);
                @(negedge clk);
            end
        end
        byte_tick = 0; reject_n = 1; addr_hit = v[21]; frame_end = 1;
        @(negedge clk);
        frame_end = 0; addr_hit = 0;
        check(req, keep_o, drop_o, v[0], !v[0]);
        @(negedge clk);
        check({req, " pulse width R10"}, keep_o, drop_o, 1'b0, 1'b0);
    endtask

    initial begin
        idle();
        {cfg_promisc, cfg_no_bcast, cfg_no_phys, cfg_lfilt_empty, cfg_runt_ok} = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 in reset", keep_o, drop_o, 1'b0, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", keep_o, drop_o, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            run_frame(TBL[i], $sformatf("vector %0d", i));
        end

        // R10: stray frame end outside a frame
        cfg_runt_ok = 0; cfg_promisc = 0;
        @(negedge clk); frame_end = 1;
        @(negedge clk); frame_end = 0;
        check("R10 stray frame_end", keep_o, drop_o, 1'b0, 1'b0);

        // R11: vetoed frame then clean frame
        run_frame({5'b00000, 1'b0, 8'd3, 4'd6, 8'd70, 1'b0}, "R11 vetoed");
        run_frame({5'b00000, 1'b0, 8'd255, 4'd0, 8'd70, 1'b1}, "R11 next clean");

        // R1: reset in mid-frame, then a frame end without a delimiter
        @(negedge clk); sfd = 1;
        @(negedge clk); sfd = 0; reject_n = 0;
        repeat (6) @(negedge clk);
        reject_n = 1; rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk); frame_end = 1;
        @(negedge clk); frame_end = 0;
        check("R1 reset mid-frame", keep_o, drop_o, 1'b0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule